// File: doc/BRIEF.md
# Oscillator Fail Flag Controller

This block keeps the sticky oscillator-fail status of a real-time clock and drives the interrupt request that reports it. The flag is raised by any event that makes the time and date untrustworthy. These events are the first application of power, software halting the oscillator, and the oscillator stopping or failing to sustain itself on the available supply. The flag then holds until software clears it.

Software clears the flag, and programs two enable bits, through a small write port. A clear is honoured only once the oscillator has run without a break for a minimum number of one-second ticks. Until then the old status survives a premature clear. The interrupt output is registered and active high. It is gated by the fail-interrupt enable, by the alarm-in-backup enable while the main supply is absent, and by the chip's reset output.

Top module: `oscfail_ctrl`

## Requirements
- R1: After reset, `fail_flag` reads 1 and `irq` reads 0.
- R2: A one-cycle pulse on `pwr_on_evt` sets `fail_flag` to 1 at the next clock edge.
- R3: While `stop_bit` is 1, `fail_flag` is set to 1 at each clock edge.
- R4: While `osc_run` is 0, `fail_flag` is set to 1 at each clock edge.
- R5: Once set, `fail_flag` stays 1 until an accepted clear. A write with `reg_wdata[0]`=1 never changes the flag.
- R6: A write with `reg_we`=1 and `reg_wdata[0]`=0 clears `fail_flag` only if at least RUN_SECS (default 4) `sec_tick` pulses have arrived since `osc_run` last was 0 or since reset. Otherwise the flag is left unchanged.
- R7: When a set cause and an accepted clear fall in the same cycle, the flag stays 1.
- R8: `irq` is 1 one cycle after a cycle in which all of these hold: the flag is 1, the fail-interrupt enable is 1, `rst_out` is 0, and either `vmain_ok` or the backup enable is 1.
- R9: `irq` falls one cycle after the flag is cleared, after the fail-interrupt enable is written to 0, or after a cycle with `rst_out`=1.
- R10: With `vmain_ok`=0, `irq` stays 0 unless the backup enable (`reg_wdata[2]`) has been written to 1.
- R11: A pulse on `flag_rd` changes neither `fail_flag` nor `irq`.
- R12: Every write loads the fail-interrupt enable from `reg_wdata[1]` and the backup enable from `reg_wdata[2]`. Both enables reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on_evt | input | 1 | Pulse on first power application |
| stop_bit | input | 1 | Software oscillator halt bit |
| osc_run | input | 1 | High while the oscillator is running |
| sec_tick | input | 1 | One-cycle pulse per second |
| vmain_ok | input | 1 | High while the main supply is present |
| rst_out | input | 1 | Chip reset output active |
| flag_rd | input | 1 | Flag register read strobe |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 3 | Write data: [0] fail flag, [1] fail-interrupt enable, [2] backup enable |
| fail_flag | output | 1 | Fail flag as read in the flag register |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
Each set cause is applied on its own: a power-on pulse, a held stop bit and a dropped run indication. This shows that every cause reaches the flag independently. Clears are attempted with zero, three and four ticks of run time, and again right after a run dropout. These attempts locate the guard boundary and show that the run count restarts. The interrupt is driven through every gate in turn, toggling each enable, the reset output and the supply mode. This separates the contribution of each term, and read strobes are mixed in to show that reading clears nothing.

// File: rtl/oscfail_pkg.sv
// Shared constants for the oscillator fail flag controller.
// Assumes the write data layout is fixed by software.
package oscfail_pkg;
    localparam int WDATA_W   = 3;
    localparam int WB_FAIL   = 0;
    localparam int WB_IE     = 1;
    localparam int WB_BKUP   = 2;
endpackage

// File: rtl/oscfail_run_timer.sv
// Measures continuous oscillator run time in one-second ticks.
// Restarts whenever osc_run drops; saturates at RUN_SECS.
// Assumes sec_tick is a single-cycle pulse.
module oscfail_run_timer #(
    parameter int RUN_SECS = 4,
    localparam int CNT_W = $clog2(RUN_SECS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_run,
    input  logic sec_tick,
    output logic run_ok
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_SECS);

    logic [CNT_W-1:0] run_cnt;

    // Count ticks while running, restart on a dropout, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_run)
            run_cnt <= '0;
        else if (sec_tick && run_cnt != LIMIT)
            run_cnt <= run_cnt + 1'b1;
    end

    // Guard satisfied once the limit is reached.
    always_comb run_ok = (run_cnt == LIMIT);
endmodule

// File: rtl/oscfail_flag.sv
// Sticky fail flag with several set causes and a guarded clear.
// A set cause in the same cycle as a clear wins. Resets to 1.
module oscfail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on_evt,
    input  logic stop_bit,
    input  logic osc_run,
    input  logic clr_req,
    input  logic run_ok,
    output logic flag_q
);
    logic set_any;
    logic clr_ok;

    // Collect set causes and the accepted clear.
    always_comb begin
        set_any = pwr_on_evt | stop_bit | ~osc_run;
        clr_ok  = clr_req & run_ok;
    end

    // Hold the flag; set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b1;
        else if (set_any)
            flag_q <= 1'b1;
        else if (clr_ok)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/oscfail_irq.sv
// Holds the two interrupt enables and produces the registered request.
// Assumes rst_out is already synchronous to clk.
module oscfail_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wr_ie,
    input  logic wr_bkup,
    input  logic flag_q,
    input  logic vmain_ok,
    input  logic rst_out,
    output logic ie_q,
    output logic bkup_q,
    output logic irq_q
);
    logic irq_d;

    // Load both enables on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            bkup_q <= 1'b0;
        end else if (we) begin
            ie_q   <= wr_ie;
            bkup_q <= wr_bkup;
        end
    end

    // Combine flag, enable, supply mode and reset output.
    always_comb irq_d = flag_q & ie_q & (vmain_ok | bkup_q) & ~rst_out;

    // Register the request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= irq_d;
    end
endmodule

// File: rtl/oscfail_ctrl.sv
// Top of the oscillator fail flag controller: run timer, sticky flag
// and interrupt gate. flag_rd is a read strobe that must have no effect.
module oscfail_ctrl #(
    parameter int RUN_SECS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pwr_on_evt,
    input  logic                             stop_bit,
    input  logic                             osc_run,
    input  logic                             sec_tick,
    input  logic                             vmain_ok,
    input  logic                             rst_out,
    input  logic                             flag_rd,
    input  logic                             reg_we,
    input  logic [oscfail_pkg::WDATA_W-1:0]  reg_wdata,
    output logic                             fail_flag,
    output logic                             irq
);
    import oscfail_pkg::*;

    logic run_ok;
    logic clr_req;
    logic ie_q;
    logic bkup_q;

    // Software clear request: a write carrying 0 in the flag bit.
    always_comb clr_req = reg_we & ~reg_wdata[WB_FAIL];

    oscfail_run_timer #(.RUN_SECS(RUN_SECS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_run  (osc_run),
        .sec_tick (sec_tick),
        .run_ok   (run_ok)
    );

    oscfail_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_on_evt (pwr_on_evt),
        .stop_bit   (stop_bit),
        .osc_run    (osc_run),
        .clr_req    (clr_req),
        .run_ok     (run_ok),
        .flag_q     (fail_flag)
    );

    oscfail_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .wr_ie    (reg_wdata[WB_IE]),
        .wr_bkup  (reg_wdata[WB_BKUP]),
        .flag_q   (fail_flag),
        .vmain_ok (vmain_ok),
        .rst_out  (rst_out),
        .ie_q     (ie_q),
        .bkup_q   (bkup_q),
        .irq_q    (irq)
    );
endmodule

// File: rtl/oscfail_ctrl_chk.sv
// Property checker for oscfail_ctrl, attached by bind.
module oscfail_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_on_evt,
    input logic       stop_bit,
    input logic       osc_run,
    input logic       rst_out,
    input logic       vmain_ok,
    input logic       flag_rd,
    input logic       reg_we,
    input logic [2:0] reg_wdata,
    input logic       run_ok,
    input logic       ie_q,
    input logic       bkup_q,
    input logic       fail_flag,
    input logic       irq
);
    p_por_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on_evt |=> fail_flag);
    p_stop_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_bit |=> fail_flag);
    p_osc_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> fail_flag);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !(reg_we && !reg_wdata[0])) |=> fail_flag);
    p_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !run_ok) |=> fail_flag);
    p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(fail_flag) && $past(ie_q)));
    p_rst_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> !irq);
    p_backup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!vmain_ok && !bkup_q) |=> !irq);
    p_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && fail_flag && !reg_we) |=> fail_flag);
endmodule

bind oscfail_ctrl oscfail_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_on_evt (pwr_on_evt),
    .stop_bit   (stop_bit),
    .osc_run    (osc_run),
    .rst_out    (rst_out),
    .vmain_ok   (vmain_ok),
    .flag_rd    (flag_rd),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .run_ok     (run_ok),
    .ie_q       (ie_q),
    .bkup_q     (bkup_q),
    .fail_flag  (fail_flag),
    .irq        (irq)
);

// File: tb/tb_oscfail_ctrl.sv
// Directed bench for oscfail_ctrl; inputs change and outputs are read at negedge.
module tb_oscfail_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on_evt = 1'b0, stop_bit = 1'b0, osc_run = 1'b1, sec_tick = 1'b0;
    logic vmain_ok = 1'b1, rst_out = 1'b0, flag_rd = 1'b0, reg_we = 1'b0;
    logic [2:0] reg_wdata = 3'b000;
    logic fail_flag, irq;
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    oscfail_ctrl dut (.*);

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] d);
        reg_we = 1'b1; reg_wdata = d; step(); reg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; step(); sec_tick = 1'b0; step();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(3); rst_n = 1'b1;
        chk("R1 flag", fail_flag, 1'b1);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_guard();
        wr(3'b000); chk("R6 no run time", fail_flag, 1'b1);
        ticks(3);
        wr(3'b000); chk("R6 three ticks", fail_flag, 1'b1);
        ticks(1);
        wr(3'b000); chk("R6 four ticks", fail_flag, 1'b0);
    endtask

    task automatic t_sticky();
        wr(3'b001); step(2); chk("R5 write one", fail_flag, 1'b0);
        pwr_on_evt = 1'b1; step(); pwr_on_evt = 1'b0;
        chk("R2 power on", fail_flag, 1'b1);
        step(3); chk("R5 held", fail_flag, 1'b1);
        wr(3'b001); chk("R5 write one keeps", fail_flag, 1'b1);
        wr(3'b000); chk("R5 clear", fail_flag, 1'b0);
    endtask

    task automatic t_stop();
        stop_bit = 1'b1; step();
        chk("R3 stop", fail_flag, 1'b1);
        wr(3'b000); chk("R7 set wins", fail_flag, 1'b1);
        stop_bit = 1'b0;
        wr(3'b000); chk("R3 clear after", fail_flag, 1'b0);
    endtask

    task automatic t_osc();
        osc_run = 1'b0; step(); osc_run = 1'b1;
        chk("R4 osc stop", fail_flag, 1'b1);
        wr(3'b000); chk("R6 restart", fail_flag, 1'b1);
        ticks(4);
        wr(3'b000); chk("R6 after restart", fail_flag, 1'b0);
    endtask

    task automatic t_irq();
        wr(3'b011); step();
        chk("R12 enable no set", fail_flag, 1'b0);
        chk("R8 idle", irq, 1'b0);
        pwr_on_evt = 1'b1; step(); pwr_on_evt = 1'b0;
        chk("R8 lag", irq, 1'b0);
        step(); chk("R8 raise", irq, 1'b1);
        flag_rd = 1'b1; step(); flag_rd = 1'b0; step();
        chk("R11 flag", fail_flag, 1'b1);
        chk("R11 irq", irq, 1'b1);
        rst_out = 1'b1; step(); rst_out = 1'b0;
        chk("R9 rst_out", irq, 1'b0);
        step(); chk("R9 rst_out release", irq, 1'b1);
        wr(3'b001); step(); chk("R9 ie off", irq, 1'b0);
        wr(3'b011); step(); chk("R12 ie on", irq, 1'b1);
        wr(3'b010); step(); chk("R9 flag clear", irq, 1'b0);
    endtask

    task automatic t_backup();
        pwr_on_evt = 1'b1; step(); pwr_on_evt = 1'b0;
        vmain_ok = 1'b0; step(2);
        chk("R10 blocked", irq, 1'b0);
        wr(3'b111); step(); chk("R10 allowed", irq, 1'b1);
        wr(3'b011); step(); chk("R10 bkup off", irq, 1'b0);
        vmain_ok = 1'b1; step(2); chk("R10 mains back", irq, 1'b1);
    endtask

    initial begin
        step(2);
        t_reset();
        t_guard();
        t_sticky();
        t_stop();
        t_osc();
        t_irq();
        t_backup();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule